// File: doc/BRIEF.md
# Memory Protection Region Checker

This block sits beside one CPU's bus and judges every access against a table of protection regions. Software programs each region with a base address, a power-of-two size, a mask that switches off any of its eight equal slices, and a code for what privileged and user code may do there. A global enable turns the check on. A second control bit decides whether privileged code may touch addresses that no region claims.

The verdict is combinational on the address phase. For each address, read/write flag and privilege flag, the block reports whether the access is permitted and which region decided it. A valid access that is refused raises a memory-management fault one clock later, together with the offending address. Memory-type bits can be stored with each region and read back, but they change no decision. With the unit disabled, every access passes untouched.

Top module: `mpu_region_guard`

## Requirements
- R1: After reset the unit is disabled, all configuration registers read 0, `acc_allow` is 1, `acc_hit` is 0 and `mm_fault` is 0.
- R2: With control bit 0 (enable) clear, every access is allowed and `acc_hit` is 0, whatever the regions hold.
- R3: Configuration word 0 holds enable (bit 0) and default-map (bit 1). For region i, word 2+2i holds the base and word 3+2i holds the attributes: bit 0 region enable, bits 5:1 size code N, bits 15:8 slice-disable mask, bits 18:16 permission, bits 23:20 memory-type. Every written field reads back unchanged and unused bits read 0.
- R4: An enabled region with size code N between 4 and 31 spans 2^(N+1) bytes and covers the addresses that agree with the base above bit N. Base bits below the region size are ignored. A size code below 4 never matches. N=31 covers the whole 4 GB space.
- R5: A region is split into eight equal slices, numbered from its low end. An address in slice k does not match the region when mask bit k is set.
- R6: When several regions match, the highest-numbered one decides, and its index appears on `acc_region` with `acc_hit` high.
- R7: The permission codes are: 0 no access; 1 privileged read/write with no user access; 2 privileged read/write with user read-only; 3 full access; 4 privileged read-only with no user access; 5 read-only for both. Codes 6 and 7 give no access.
- R8: An address that no region matches gives `acc_hit`=0 and `acc_region`=0. It is allowed only for a privileged access while default-map is set.
- R9: A valid, refused access sets `mm_fault` for exactly the next cycle and loads its address into `mm_fault_addr`. That address holds until the next fault. Refused addresses presented without `acc_valid` raise no fault.
- R10: The memory-type bits are stored and read back but do not change any verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| acc_valid | input | 1 | An access is present this cycle |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_priv | input | 1 | 1 for privileged, 0 for user |
| acc_allow | output | 1 | Access permitted |
| acc_hit | output | 1 | A region decided the access |
| acc_region | output | RIDX_W | Index of the deciding region |
| mm_fault | output | 1 | Registered fault pulse |
| mm_fault_addr | output | 32 | Address of the last faulting access |

## Verification
The bench probes the edges of each region: the last byte inside, the first byte outside, and a slice whose mask bit is set. An off-by-one in the size mask or in the slice index would let a neighbouring address through or reject a legal one. A low region is overlapped by a higher one and a region with no-access is overlapped by a 4 GB region, so a priority inverter would return the wrong index and the wrong verdict. Each permission code is tried with read, write, user and privileged accesses, so a swapped code shows up as a wrong grant. Further tests cover the unmatched-address path with default-map on and off, the one-cycle fault pulse and its held address, a refused address presented without `acc_valid`, and memory-type bits rewritten with no effect on the verdict.

// File: rtl/mpu_guard_pkg.sv
package mpu_guard_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int SUBS   = 8;
  localparam int MIN_N  = 4;

  typedef enum logic [2:0] {
    PERM_NONE    = 3'd0,
    PERM_PRW     = 3'd1,
    PERM_PRW_URO = 3'd2,
    PERM_FULL    = 3'd3,
    PERM_PRO     = 3'd4,
    PERM_RO      = 3'd5
  } perm_e;

  typedef struct packed {
    logic [3:0] memattr;
    logic [2:0] perm;
    logic [7:0] sub_off;
    logic [4:0] size_n;
    logic       en;
  } region_attr_t;

  function automatic region_attr_t attr_from_word(input logic [DATA_W-1:0] w);
    region_attr_t a;
    a.en      = w[0];
    a.size_n  = w[5:1];
    a.sub_off = w[15:8];
    a.perm    = w[18:16];
    a.memattr = w[23:20];
    return a;
  endfunction

  function automatic logic [DATA_W-1:0] attr_to_word(input region_attr_t a);
    return {8'h00, a.memattr, 1'b0, a.perm, a.sub_off, 2'b00, a.size_n, a.en};
  endfunction

  // True when addr lies within the 2^(n+1)-byte window containing base.
  function automatic logic region_covers(input logic [ADDR_W-1:0] addr,
                                         input logic [ADDR_W-1:0] base,
                                         input logic [4:0] n);
    logic [ADDR_W:0] span;
    if (int'(n) < MIN_N) return 1'b0;
    span = ({{ADDR_W{1'b0}}, 1'b1} << (int'(n) + 1)) - 1'b1;
    return ((addr ^ base) & ~span[ADDR_W-1:0]) == '0;
  endfunction

  // Which eighth of the region the address falls in.
  function automatic logic [2:0] slice_of(input logic [ADDR_W-1:0] addr,
                                          input logic [4:0] n);
    logic [ADDR_W-1:0] sh;
    sh = addr >> (int'(n) - 2);
    return sh[2:0];
  endfunction

  function automatic logic perm_allows(input logic [2:0] perm,
                                       input logic priv,
                                       input logic write);
    case (perm)
      PERM_PRW:     return priv;
      PERM_PRW_URO: return priv | ~write;
      PERM_FULL:    return 1'b1;
      PERM_PRO:     return priv & ~write;
      PERM_RO:      return ~write;
      default:      return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
  import mpu_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int CFG_AW      = $clog2(2*NUM_REGIONS+2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [CFG_AW-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic                 ctl_en,
  output logic                 ctl_defmap,
  output logic [ADDR_W-1:0]    base_o [NUM_REGIONS],
  output region_attr_t         attr_o [NUM_REGIONS]
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en     <= 1'b0;
      ctl_defmap <= 1'b0;
    end else if (we && addr == '0) begin
      ctl_en     <= wdata[0];
      ctl_defmap <= wdata[1];
    end
  end

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_reg
    localparam logic [CFG_AW-1:0] BASE_IDX = CFG_AW'(2 + 2*i);
    localparam logic [CFG_AW-1:0] ATTR_IDX = CFG_AW'(3 + 2*i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_o[i] <= '0;
        attr_o[i] <= '0;
      end else if (we && addr == BASE_IDX) begin
        base_o[i] <= wdata;
      end else if (we && addr == ATTR_IDX) begin
        attr_o[i] <= attr_from_word(wdata);
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata = {{(DATA_W-2){1'b0}}, ctl_defmap, ctl_en};
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (addr == CFG_AW'(2 + 2*i)) rdata = base_o[i];
      if (addr == CFG_AW'(3 + 2*i)) rdata = attr_to_word(attr_o[i]);
    end
  end
endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_guard_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  region_attr_t      attr,
  output logic              hit
);
  logic       in_window;
  logic [2:0] slice;

  always_comb begin
    in_window = region_covers(addr, base, attr.size_n);
    slice     = slice_of(addr, attr.size_n);
    hit       = attr.en & in_window & ~attr.sub_off[slice];
  end
endmodule

// File: rtl/mpu_fault_reg.sv
module mpu_fault_reg
  import mpu_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_ev,
  input  logic [ADDR_W-1:0] addr,
  output logic              fault_q,
  output logic [ADDR_W-1:0] fault_addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q      <= 1'b0;
      fault_addr_q <= '0;
    end else begin
      fault_q <= fault_ev;
      if (fault_ev) fault_addr_q <= addr;
    end
  end
endmodule

// File: rtl/mpu_region_guard.sv
module mpu_region_guard
  import mpu_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int CFG_AW      = $clog2(2*NUM_REGIONS+2),
  parameter int RIDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               acc_valid,
  input  logic [31:0]        acc_addr,
  input  logic               acc_write,
  input  logic               acc_priv,
  output logic               acc_allow,
  output logic               acc_hit,
  output logic [RIDX_W-1:0]  acc_region,
  output logic               mm_fault,
  output logic [31:0]        mm_fault_addr
);
  logic               ctl_en;
  logic               ctl_defmap;
  logic [ADDR_W-1:0]  base_r [NUM_REGIONS];
  region_attr_t       attr_r [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hit_vec;
  logic               sel_hit;
  logic [RIDX_W-1:0]  sel_idx;
  logic               ev_fault_now;

  mpu_cfg_regs #(.NUM_REGIONS(NUM_REGIONS), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .ctl_en(ctl_en), .ctl_defmap(ctl_defmap),
    .base_o(base_r), .attr_o(attr_r)
  );

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_match
    mpu_region_match u_match (
      .addr(acc_addr), .base(base_r[i]), .attr(attr_r[i]), .hit(hit_vec[i])
    );
  end

  // Highest-numbered hit wins: later iterations overwrite earlier ones.
  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit_vec[i]) begin
        sel_hit = 1'b1;
        sel_idx = RIDX_W'(i);
      end
    end
  end

  always_comb begin
    if (!ctl_en)      acc_allow = 1'b1;
    else if (sel_hit) acc_allow = perm_allows(attr_r[sel_idx].perm, acc_priv, acc_write);
    else              acc_allow = acc_priv & ctl_defmap;
    acc_hit    = ctl_en & sel_hit;
    acc_region = acc_hit ? sel_idx : '0;
  end

  assign ev_fault_now = acc_valid & ~acc_allow;

  mpu_fault_reg u_fault (
    .clk(clk), .rst_n(rst_n), .fault_ev(ev_fault_now), .addr(acc_addr),
    .fault_q(mm_fault), .fault_addr_q(mm_fault_addr)
  );
endmodule

// File: rtl/mpu_guard_checker.sv
module mpu_guard_checker #(
  parameter int NUM_REGIONS = 8,
  parameter int RIDX_W      = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acc_valid,
  input logic [31:0]            acc_addr,
  input logic                   acc_allow,
  input logic                   acc_hit,
  input logic [RIDX_W-1:0]      acc_region,
  input logic                   mm_fault,
  input logic [31:0]            mm_fault_addr,
  input logic                   ctl_en,
  input logic [NUM_REGIONS-1:0] hit_vec
);
  assert_fault_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_allow) |=> (mm_fault && mm_fault_addr == $past(acc_addr)));

  assert_no_spurious_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_allow) |=> (!mm_fault && $stable(mm_fault_addr)));

  assert_bypass_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> (acc_allow && !acc_hit));

  assert_highest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> ((hit_vec >> acc_region) == NUM_REGIONS'(1)));

  assert_unmatched_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && hit_vec == '0) |-> (!acc_hit && acc_region == '0));
endmodule

bind mpu_region_guard mpu_guard_checker #(.NUM_REGIONS(NUM_REGIONS), .RIDX_W(RIDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_allow(acc_allow), .acc_hit(acc_hit), .acc_region(acc_region),
  .mm_fault(mm_fault), .mm_fault_addr(mm_fault_addr), .ctl_en(ctl_en),
  .hit_vec(hit_vec)
);

// File: tb/mpu_region_guard_bench.sv
module mpu_region_guard_bench;
  localparam int NR     = 8;
  localparam int CFG_AW = $clog2(2*NR+2);
  localparam int RW     = $clog2(NR);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CFG_AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic acc_write = 1'b0;
  logic acc_priv = 1'b0;
  logic acc_allow, acc_hit, mm_fault;
  logic [RW-1:0] acc_region;
  logic [31:0] mm_fault_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mpu_region_guard #(.NUM_REGIONS(NR)) u_mpu_region_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_priv(acc_priv),
    .acc_allow(acc_allow), .acc_hit(acc_hit), .acc_region(acc_region),
    .mm_fault(mm_fault), .mm_fault_addr(mm_fault_addr)
  );

  // {addr, write, priv, exp_allow, exp_hit, exp_region}
  localparam int NV = 28;
  localparam logic [38:0] VECS [NV] = '{
    {32'h0000_1000, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0}, // R7 full access
    {32'h0000_8010, 1'b0, 1'b1, 1'b1, 1'b1, 3'd1}, // R6 overlap, R7 code 4 read
    {32'h0000_8010, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1}, // R7 code 4 write
    {32'h0000_8010, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1}, // R7 code 4 user
    {32'h0000_9000, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0}, // R4 past region1 end
    {32'h0000_FFFF, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0}, // R4 last byte
    {32'h0001_0000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0}, // R8 defmap priv
    {32'h0001_0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R8 user unmatched
    {32'h2000_0800, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2}, // R7 code 2 user read
    {32'h2000_0800, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2}, // R7 code 2 user write
    {32'h2000_0800, 1'b1, 1'b1, 1'b1, 1'b1, 3'd2}, // R7 code 2 priv write
    {32'h2000_1000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0}, // R5 slice 2 off
    {32'h2000_1000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R5 slice 2 off user
    {32'h2000_17FF, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R5 slice 2 end
    {32'h2000_1800, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2}, // R5 slice 3 on
    {32'h2000_3FFF, 1'b1, 1'b1, 1'b1, 1'b1, 3'd2}, // R4 last byte
    {32'h2000_4000, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0}, // R4 first byte out
    {32'h4000_001F, 1'b1, 1'b1, 1'b1, 1'b1, 3'd3}, // R4 32-byte region, R7 code 1
    {32'h4000_0020, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0}, // R4 outside 32B
    {32'h4000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3}, // R7 code 1 user
    {32'h6000_03FF, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4}, // R7 code 5 read
    {32'h6000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 3'd4}, // R7 code 5 write
    {32'h8000_0000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0}, // R4 N=3 never matches
    {32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R4 N=3 user
    {32'hA000_0100, 1'b0, 1'b1, 1'b0, 1'b1, 3'd6}, // R7 code 0, R4 base low bits
    {32'hA000_01FF, 1'b0, 1'b1, 1'b0, 1'b1, 3'd6}, // R7 code 0 end
    {32'hA000_0200, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0}, // R4 outside
    {32'hC000_0000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0}  // R4 region disabled
  };

  function automatic logic [31:0] mk_attr(input logic en, input logic [4:0] n,
      input logic [7:0] srd, input logic [2:0] perm, input logic [3:0] mem);
    return {8'h00, mem, 1'b0, perm, srd, 2'b00, n, en};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = CFG_AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_chk(input string tag, input int a, input logic [31:0] exp);
    cfg_addr = CFG_AW'(a);
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic access(input logic v, input logic [31:0] a, input logic w, input logic p);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_write = w; acc_priv = p;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cfg_chk("R1 ctrl", 0, 32'h0);
    cfg_chk("R1 base0", 2, 32'h0);
    cfg_chk("R1 attr7", 17, 32'h0);
    access(1'b0, 32'h1234_0000, 1'b1, 1'b0);
    check("R1 allow", {31'b0, acc_allow}, 32'd1);
    check("R1 hit", {31'b0, acc_hit}, 32'd0);
    check("R1 fault", {31'b0, mm_fault}, 32'd0);

    // Region setup (base at 2+2i, attributes at 3+2i)
    cfg_wr(2, 32'h0000_0000);  cfg_wr(3,  mk_attr(1'b1, 5'd15, 8'h00, 3'd3, 4'h0));
    cfg_wr(4, 32'h0000_8000);  cfg_wr(5,  mk_attr(1'b1, 5'd11, 8'h00, 3'd4, 4'h0));
    cfg_wr(6, 32'h2000_0000);  cfg_wr(7,  mk_attr(1'b1, 5'd13, 8'h04, 3'd2, 4'h0));
    cfg_wr(8, 32'h4000_0000);  cfg_wr(9,  mk_attr(1'b1, 5'd4,  8'h00, 3'd1, 4'h0));
    cfg_wr(10, 32'h6000_0000); cfg_wr(11, mk_attr(1'b1, 5'd9,  8'h00, 3'd5, 4'h3));
    cfg_wr(12, 32'h8000_0000); cfg_wr(13, mk_attr(1'b1, 5'd3,  8'h00, 3'd3, 4'h0));
    cfg_wr(14, 32'hA000_0155); cfg_wr(15, mk_attr(1'b1, 5'd7,  8'h00, 3'd0, 4'h0));
    cfg_wr(16, 32'hC000_0000); cfg_wr(17, mk_attr(1'b0, 5'd20, 8'h00, 3'd3, 4'h0));
    cfg_wr(0, 32'h3);

    // R3 readback
    cfg_chk("R3 ctrl", 0, 32'h3);
    cfg_chk("R3 base6", 14, 32'hA000_0155);
    cfg_chk("R3 attr2", 7, mk_attr(1'b1, 5'd13, 8'h04, 3'd2, 4'h0));
    cfg_chk("R3 attr4", 11, mk_attr(1'b1, 5'd9, 8'h00, 3'd5, 4'h3));

    for (int k = 0; k < NV; k++) begin
      access(1'b1, VECS[k][38:7], VECS[k][6], VECS[k][5]);
      check($sformatf("R7/R4 vec%0d allow", k), {31'b0, acc_allow}, {31'b0, VECS[k][4]});
      check($sformatf("R6/R8 vec%0d hit", k), {31'b0, acc_hit}, {31'b0, VECS[k][3]});
      check($sformatf("R6/R8 vec%0d region", k), {29'b0, acc_region}, {29'b0, VECS[k][2:0]});
    end
    access(1'b0, 32'h0000_1000, 1'b0, 1'b1);

    // R8 default map off: privileged unmatched access refused
    cfg_wr(0, 32'h1);
    access(1'b0, 32'h0001_0000, 1'b0, 1'b1);
    check("R8 defmap off priv", {31'b0, acc_allow}, 32'd0);

    // R9 fault pulse and held address
    access(1'b1, 32'h0001_0000, 1'b0, 1'b1);
    access(1'b0, 32'h0000_1000, 1'b0, 1'b1);
    check("R9 fault pulse", {31'b0, mm_fault}, 32'd1);
    check("R9 fault addr", mm_fault_addr, 32'h0001_0000);
    access(1'b0, 32'h0000_1000, 1'b0, 1'b1);
    check("R9 fault one cycle", {31'b0, mm_fault}, 32'd0);
    check("R9 addr held", mm_fault_addr, 32'h0001_0000);
    access(1'b0, 32'h0002_0000, 1'b1, 1'b0);
    access(1'b0, 32'h0000_1000, 1'b0, 1'b1);
    check("R9 no fault without valid", {31'b0, mm_fault}, 32'd0);
    check("R9 addr unchanged", mm_fault_addr, 32'h0001_0000);

    // R10 memory-type bits have no effect
    cfg_wr(11, mk_attr(1'b1, 5'd9, 8'h00, 3'd5, 4'hA));
    cfg_chk("R10 readback", 11, mk_attr(1'b1, 5'd9, 8'h00, 3'd5, 4'hA));
    access(1'b0, 32'h6000_03FF, 1'b0, 1'b0);
    check("R10 allow", {31'b0, acc_allow}, 32'd1);
    check("R10 region", {29'b0, acc_region}, 32'd4);

    // R2 unit disabled
    cfg_wr(0, 32'h0);
    access(1'b1, 32'hA000_0100, 1'b1, 1'b0);
    check("R2 allow", {31'b0, acc_allow}, 32'd1);
    check("R2 hit", {31'b0, acc_hit}, 32'd0);
    access(1'b0, 32'h0, 1'b0, 1'b0);
    check("R2 no fault", {31'b0, mm_fault}, 32'd0);

    // R4/R6 whole-space region at top priority
    cfg_wr(0, 32'h3);
    cfg_wr(16, 32'h0000_0000);
    cfg_wr(17, mk_attr(1'b1, 5'd31, 8'h00, 3'd3, 4'h0));
    access(1'b0, 32'hA000_0100, 1'b0, 1'b1);
    check("R6 4GB overrides", {31'b0, acc_allow}, 32'd1);
    check("R4 4GB region", {29'b0, acc_region}, 32'd7);
    access(1'b0, 32'h1234_5678, 1'b1, 1'b0);
    check("R4 4GB user write", {31'b0, acc_allow}, 32'd1);
    check("R4 4GB hit", {31'b0, acc_hit}, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule